// File: doc/BRIEF.md
# Period Timer with Match-Driven Clear

This block is a 16-bit up-counter with a sticky overflow flag and an interrupt output. Its count is compared against a programmable 16-bit compare value. In the special-event compare mode, a match clears the counter instead of advancing it, so the compare value sets the timer's period. The same match also sends a one-clock start strobe to a downstream analog-to-digital converter. A divide-by-1/2/4/8 prescaler sets how often the counter steps.

Software reaches every field through a byte-wide register port. A read of the count's low byte captures its high byte, so software can read the 16-bit value coherently. A write to the counter always wins over a match clear that falls on the same clock.

Register offsets on `addr`: 0 count low byte, 1 count high byte, 2 compare low byte, 3 compare high byte, 4 control, 5 compare mode, 6 flag. Control bits: bit0 run, bits2:1 prescale select, bit3 synchronous-mode enable, bit4 buffered high-byte read, bit5 interrupt enable. Compare mode is held in bits 3:0 of offset 5. The overflow flag is bit 0 of offset 6.

Top module: `tmr_period_unit`

## Requirements
- R1: Each prescaled step adds one to the count, and a step from 16'hFFFF gives 16'h0000.
- R2: A step that wraps the count from 16'hFFFF to 16'h0000 sets the flag (offset 6 bit0). The flag stays set until software writes 0 to that bit.
- R3: `irq` is high exactly when the flag and the interrupt enable (control bit5) are both set.
- R4: On a step where the compare mode is 4'b1011, control bit3 is set and the count equals the compare value, the count becomes 16'h0000 instead of incrementing. In any other mode, or with bit3 clear, the count increments as normal.
- R5: A match clear never sets the flag, including when the compare value is 16'hFFFF.
- R6: A counter byte write (offset 0 or 1) on the same clock as a match clear loads the written byte, and the clear is dropped.
- R7: `conv_start` goes high for one clock, on the clock after a step in mode 4'b1011 at which the count equals the compare value, and only if `adc_en` was high. The strobe does not depend on control bit3.
- R8: Prescale select 0, 1, 2 or 3 makes the count step once every 1, 2, 4 or 8 clocks while control bit0 is set. While control bit0 is clear, the count holds.
- R9: A read of offset 0 copies the live high byte into a buffer. With control bit4 set, a read of offset 1 returns that buffer; with bit4 clear, it returns the live high byte.
- R10: Synchronous reset clears the count, the compare value, the control and mode fields, the flag and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| adc_en | input | 1 | Converter enabled; gates the start strobe |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | One-clock converter start strobe |

## Verification
The counter is run from known preloads at each of the four prescale ratios, and across the 16'hFFFF boundary, so that step rate and wrap are checked on their own. The special-event path is run with the mode field, the synchronous bit and `adc_en` each varied one at a time, which separates the clear decision from the strobe decision. A compare value of 16'hFFFF shows whether a clear is mistaken for a wrap. A counter write placed on the same clock as a match shows which of the two wins. Buffered and live high-byte reads after a high-byte rewrite tell the two read paths apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        A_CNT_LO = 3'd0,
        A_CNT_HI = 3'd1,
        A_CMP_LO = 3'd2,
        A_CMP_HI = 3'd3,
        A_CTRL   = 3'd4,
        A_MODE   = 3'd5,
        A_FLAG   = 3'd6
    } reg_addr_e;

    // Control byte layout, MSB first: bit5 .. bit0
    typedef struct packed {
        logic       irq_en;
        logic       buf_rd;
        logic       sync;
        logic [1:0] ps;
        logic       on;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_SPECIAL = 4'b1011;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PS_W  = 2,
    parameter int PRE_W = (1 << PS_W) - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] limit;

    // limit = 2**ps - 1 built as a thermometer code
    always_comb begin
        limit = '0;
        for (int i = 0; i < PRE_W; i++) begin
            limit[i] = (i < int'(ps));
        end
    end

    always_comb begin
        tick  = run && (pre_q == limit);
        if (!run || tick) pre_d = '0;
        else              pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && (ps != '0)) |-> !tick) else $error("tick spacing"); // R8

endmodule

// File: rtl/tmr_match.sv
module tmr_match
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  cmp,
    input  logic [MODE_W-1:0] mode,
    input  logic              tick,
    output logic              match_evt
);
    logic equal;
    logic special;

    always_comb begin
        equal     = (cnt == cmp);
        special   = (mode == MODE_SPECIAL);
        match_evt = tick && special && equal;
    end

endmodule

// File: rtl/tmr_period_unit.sv
module tmr_period_unit
    import tmr_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int PS_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             adc_en,
    output logic             irq,
    output logic             conv_start
);
    localparam int CNT_W = 2 * BUS_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cmp;
        logic [BUS_W-1:0]  hi_buf;
        ctrl_t             ctrl;
        logic [MODE_W-1:0] mode;
        logic              flag;
        logic              conv;
    } state_t;

    state_t s_d, s_q;

    logic tick, match_evt, match_rst;
    logic wr_lo, wr_hi, wr_cnt, wr_flag, wrap;

    tmr_prescale #(.PS_W(PS_W)) u_pre (
        .clk (clk),
        .rst (rst),
        .run (s_q.ctrl.on),
        .ps  (s_q.ctrl.ps),
        .tick(tick)
    );

    tmr_match #(.CNT_W(CNT_W)) u_match (
        .cnt      (s_q.cnt),
        .cmp      (s_q.cmp),
        .mode     (s_q.mode),
        .tick     (tick),
        .match_evt(match_evt)
    );

    always_comb begin
        s_d       = s_q;
        wr_lo     = wr_en && (addr == A_CNT_LO);
        wr_hi     = wr_en && (addr == A_CNT_HI);
        wr_cnt    = wr_lo || wr_hi;
        wr_flag   = wr_en && (addr == A_FLAG);
        match_rst = match_evt && s_q.ctrl.sync;
        wrap      = tick && !match_rst && !wr_cnt && (&s_q.cnt);

        // counter: software write, then match clear, then step
        if (wr_cnt) begin
            if (wr_lo) s_d.cnt[BUS_W-1:0]     = wdata;
            if (wr_hi) s_d.cnt[CNT_W-1:BUS_W] = wdata;
        end else if (match_rst) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end

        if (wr_en && addr == A_CMP_LO) s_d.cmp[BUS_W-1:0]     = wdata;
        if (wr_en && addr == A_CMP_HI) s_d.cmp[CNT_W-1:BUS_W] = wdata;
        if (wr_en && addr == A_CTRL)   s_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
        if (wr_en && addr == A_MODE)   s_d.mode = wdata[MODE_W-1:0];

        // flag: hardware set beats a coincident software clear
        if (wr_flag) s_d.flag = wdata[0];
        if (wrap)    s_d.flag = 1'b1;

        if (rd_en && addr == A_CNT_LO) s_d.hi_buf = s_q.cnt[CNT_W-1:BUS_W];

        s_d.conv = match_evt && adc_en;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        case (addr)
            A_CNT_LO: rdata = s_q.cnt[BUS_W-1:0];
            A_CNT_HI: rdata = s_q.ctrl.buf_rd ? s_q.hi_buf : s_q.cnt[CNT_W-1:BUS_W];
            A_CMP_LO: rdata = s_q.cmp[BUS_W-1:0];
            A_CMP_HI: rdata = s_q.cmp[CNT_W-1:BUS_W];
            A_CTRL:   rdata = {{(BUS_W-CTRL_W){1'b0}}, s_q.ctrl};
            A_MODE:   rdata = {{(BUS_W-MODE_W){1'b0}}, s_q.mode};
            A_FLAG:   rdata = {{(BUS_W-1){1'b0}}, s_q.flag};
            default:  rdata = '0;
        endcase
    end

    assign irq        = s_q.flag && s_q.ctrl.irq_en;
    assign conv_start = s_q.conv;

    AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(match_rst && !wr_cnt)) |-> (s_q.cnt == '0)) else $error("match clear"); // R4
    AST_MATCH_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(match_rst && !s_q.flag && !wr_flag)) |-> !s_q.flag) else $error("flag on clear"); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && addr == A_CNT_LO)) |-> (s_q.cnt[BUS_W-1:0] == $past(wdata))) else $error("write prio"); // R6
    AST_STROBE_ADC: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (!$past(rst) && $past(adc_en))) else $error("strobe gate"); // R7
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
        irq |-> s_q.ctrl.irq_en) else $error("irq gate"); // R3
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!s_q.ctrl.on && !wr_cnt)) |-> (s_q.cnt == $past(s_q.cnt))) else $error("hold"); // R8

endmodule

// File: tb/tmr_period_unit_test.sv
`timescale 1ns/1ps
module tmr_period_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, adc_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, conv_start;

    int n_vec = 0, n_bad = 0, conv_cnt = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    tmr_period_unit uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .adc_en(adc_en), .irq(irq), .conv_start(conv_start)
    );

    // monitor: compares each read against the scoreboard head
    always @(posedge clk) begin
        if (rd_en && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            #2;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    always @(negedge clk) if (conv_start) conv_cnt++;

    // all tasks start and end at a negedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
    endtask

    task automatic chk_cnt(input logic [15:0] v, input string t);
        rd(3'd0, v[7:0], t); rd(3'd1, v[15:8], t);
    endtask

    task automatic run(input logic [7:0] c, input int k);
        wr(3'd4, c | 8'h01);
        repeat (k) @(negedge clk);
        wr(3'd4, c);
    endtask

    task automatic chk(input logic act, input logic e, input string t);
        n_vec++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, e);
        end
    endtask

    task automatic chk_int(input int act, input int e, input string t);
        n_vec++;
        if (act != e) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, e);
        end
    endtask

    task automatic pulse_rst();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        for (int a = 0; a < 7; a++) rd(a[2:0], 8'h00, "R10 reset reg");
        chk(irq, 1'b0, "R10 irq");
        chk(conv_start, 1'b0, "R10 conv");

        // R1 R8 divide by 1: 10 steps
        set_cnt(16'h0010); run(8'h00, 9); chk_cnt(16'h001A, "R1 R8 div1");
        // R8 divide by 2, 4, 8
        set_cnt(16'h0000); run(8'h02, 6);  chk_cnt(16'h0003, "R8 div2");
        set_cnt(16'h0000); run(8'h04, 9);  chk_cnt(16'h0002, "R8 div4");
        set_cnt(16'h0000); run(8'h06, 16); chk_cnt(16'h0002, "R8 div8");
        // R8 hold while off
        set_cnt(16'h1234); repeat (20) @(negedge clk); chk_cnt(16'h1234, "R8 hold");

        // R1 R2 R3 overflow
        wr(3'd4, 8'h20);
        set_cnt(16'hFFFE); run(8'h20, 2); chk_cnt(16'h0001, "R1 wrap");
        repeat (5) @(negedge clk);
        rd(3'd6, 8'h01, "R2 sticky flag");
        chk(irq, 1'b1, "R3 irq on");
        wr(3'd4, 8'h00);
        chk(irq, 1'b0, "R3 irq gated");
        rd(3'd6, 8'h01, "R2 flag kept");
        wr(3'd6, 8'h00);
        rd(3'd6, 8'h00, "R2 flag cleared");

        // R4 R5 R7 special-event match
        wr(3'd5, 8'h0B); wr(3'd2, 8'h05); wr(3'd3, 8'h00);
        adc_en = 1'b1;
        set_cnt(16'h0000); conv_cnt = 0; run(8'h08, 6);
        chk_cnt(16'h0001, "R4 match clear");
        rd(3'd6, 8'h00, "R5 no flag");
        chk_int(conv_cnt, 1, "R7 strobe");
        // R4 R7 sync bit off
        set_cnt(16'h0000); conv_cnt = 0; run(8'h00, 6);
        chk_cnt(16'h0007, "R4 sync off");
        chk_int(conv_cnt, 1, "R7 strobe without sync");
        // R7 adc disabled
        adc_en = 1'b0;
        set_cnt(16'h0000); conv_cnt = 0; run(8'h08, 6);
        chk_cnt(16'h0001, "R4 adc off");
        chk_int(conv_cnt, 0, "R7 adc gate");
        // R4 R7 other mode
        adc_en = 1'b1; wr(3'd5, 8'h0A);
        set_cnt(16'h0000); conv_cnt = 0; run(8'h08, 6);
        chk_cnt(16'h0007, "R4 mode other");
        chk_int(conv_cnt, 0, "R7 mode other");

        // R5 compare at FFFF
        wr(3'd5, 8'h0B); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        set_cnt(16'hFFFE); run(8'h08, 2);
        chk_cnt(16'h0001, "R5 clear at top");
        rd(3'd6, 8'h00, "R5 flag at top");

        // R6 write wins over coincident match
        wr(3'd2, 8'h03); wr(3'd3, 8'h00);
        set_cnt(16'h0003); conv_cnt = 0;
        wr(3'd4, 8'h09);
        wr(3'd0, 8'h40);
        wr(3'd4, 8'h08);
        chk_cnt(16'h0041, "R6 write wins");
        chk_int(conv_cnt, 1, "R7 strobe on write cycle");

        // R9 buffered high byte
        wr(3'd5, 8'h00);
        set_cnt(16'hAB12); wr(3'd4, 8'h10);
        rd(3'd0, 8'h12, "R9 low read");
        wr(3'd1, 8'h77);
        rd(3'd1, 8'hAB, "R9 buffered hi");
        wr(3'd4, 8'h00);
        rd(3'd1, 8'h77, "R9 live hi");

        // R10 reset after activity
        wr(3'd4, 8'h3E); wr(3'd2, 8'h55); wr(3'd5, 8'h0B); wr(3'd6, 8'h01);
        pulse_rst();
        for (int a = 0; a < 7; a++) rd(a[2:0], 8'h00, "R10 second reset");
        chk(irq, 1'b0, "R10 irq after reset");

        repeat (3) @(negedge clk);
        chk_int(exp_q.size(), 0, "scoreboard drained");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule